// File: doc/BRIEF.md
# Pixel Word Framer and Encoder

This block sits on the transmit side of a serial video link and runs on the pixel clock. Each cycle it takes one 24-bit colour pixel with horizontal sync, vertical sync and a data-enable flag. It turns them into one 30-bit line word for a downstream serializer that shifts out 30 bits per pixel clock. The word holds three 10-bit symbols of a DC-balanced 8b/10b code, so the serial rate is thirty times the pixel rate.

On an active pixel, each symbol carries one colour byte as a data character. During blanking the colour bus is ignored. All three symbol slots then carry the same comma-bearing control character, and the receiver reads the sync state from which control character it is. Two configuration inputs set whether each incoming sync is active low or active high, so the link always carries syncs in one internal polarity. Running disparity is threaded through the three lanes inside one cycle and across cycles, which keeps the line DC balanced.

Top module: `pixel_framer`

## Requirements
- R1: The internal horizontal sync equals `hsync_i` XOR `hs_pol_i`. A polarity input of 1 marks the incoming sync as active low, and 0 marks it as active high. The vertical sync uses `vsync_i` and `vs_pol_i` under the same rule.
- R2: The word for the inputs sampled at a rising clock edge appears on `word_o` right after that edge. Lane A (`rgb_i[23:16]`) goes in `word_o[29:20]`, lane B (`rgb_i[15:8]`) in `word_o[19:10]`, and lane C (`rgb_i[7:0]`) in `word_o[9:0]`. Inside each symbol, bit 9 is code bit a and bit 0 is code bit j, so lane A bit a is sent first.
- R3: Every symbol contains four, five or six ones. Take the running disparity as −1 at reset and add each symbol's disparity (2·ones − 10) in lane order A, B, C. The running value after every symbol is then −1 or +1.
- R4: With `de_i` high, each lane carries the standard 8b/10b data character D.x.y for its byte, where x is the byte's bits [4:0] and y its bits [7:5]. The 6-bit and 4-bit sub-blocks are chosen by the running disparity current at that symbol.
- R5: With `de_i` low, all three lanes carry control character K28.y, where y is chosen by the internal sync state (vsync, hsync): 00 gives K28.5, 01 gives K28.1, 10 gives K28.2 and 11 gives K28.3. Each is encoded at the running disparity current at its symbol.
- R6: With `de_i` low, the value of `rgb_i` has no effect on `word_o` or on the running disparity.
- R7: While `rst` is high at a clock edge, `word_o` becomes K28.5 in all three lanes, encoded starting from negative disparity. That word is 0011111010, 1100000101, 0011111010 for lanes A, B, C, and the running disparity after it is positive.
- R8: For y = 7, the alternate sub-block (0111 / 1000) replaces the primary one (1110 / 0001) when the disparity is negative and x is 17, 18 or 20, or when it is positive and x is 11, 13 or 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rgb_i | input | 24 | Pixel colour, lanes A/B/C from the top byte down |
| hsync_i | input | 1 | Horizontal sync as received |
| vsync_i | input | 1 | Vertical sync as received |
| de_i | input | 1 | Data enable, high on active pixels |
| hs_pol_i | input | 1 | 1: incoming hsync is active low |
| vs_pol_i | input | 1 | 1: incoming vsync is active low |
| word_o | output | 30 | Three 10-bit symbols, lane A in the top bits |

## Verification
The bench sweeps all 256 byte values through every lane at both disparity phases. This reaches the neutral sub-blocks that must alternate (D.7 and D.x.3) and the y = 7 alternate sub-block cases. A design that gets these wrong drifts to a running disparity of ±3 or emits the wrong code for bytes such as 0xF1 or 0xEB. It also drives every sync combination under all four polarity settings with colour noise during blanking. A swapped polarity or a swapped K28 mapping shows up as the wrong control character, and a leak from the colour bus shows up as a data character in blanking. Reset is applied both at start and mid-stream, followed by a pixel whose lane codes are written out literally, which catches a reversed lane order, an extra register stage or a reset that leaves the disparity positive.

// File: rtl/pixel_framer_pkg.sv
package pixel_framer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYM_W  = BYTE_W + 2;
  localparam logic [4:0] K_X     = 5'd28;

  // y field of the K28.y control character for each (vsync, hsync) state
  localparam logic [2:0] KY_IDLE  = 3'd5;
  localparam logic [2:0] KY_HSYNC = 3'd1;
  localparam logic [2:0] KY_VSYNC = 3'd2;
  localparam logic [2:0] KY_BOTH  = 3'd3;

  function automatic logic [BYTE_W-1:0] ctrl_byte(input logic vs, input logic hs);
    logic [2:0] y;
    case ({vs, hs})
      2'b01:   y = KY_HSYNC;
      2'b10:   y = KY_VSYNC;
      2'b11:   y = KY_BOTH;
      default: y = KY_IDLE;
    endcase
    return {y, K_X};
  endfunction
endpackage

// File: rtl/sym_enc8b10b.sv
module sym_enc8b10b
  import pixel_framer_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              k_i,
  input  logic              rd_i,     // 1: positive running disparity
  output logic [SYM_W-1:0]  sym_o,
  output logic              rd_o
);
  // 6-bit sub-block, negative-disparity column (abcdei)
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // 4-bit sub-block for data, negative-disparity column (fghj)
  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  // 4-bit sub-block for K28.y when the 6-bit part left disparity positive
  function automatic logic [3:0] four_k(input logic [2:0] y);
    case (y)
      3'd0: return 4'b0100;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b0011;
      3'd4: return 4'b0010;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1000;
    endcase
  endfunction

  logic [4:0] x;
  logic [2:0] y;
  logic [5:0] six_n, six;
  logic [3:0] four_n, four;
  logic       rd6, alt7, flip6, flip4;

  always_comb begin
    x      = byte_i[4:0];
    y      = byte_i[7:5];
    six_n  = k_i ? 6'b001111 : six_neg(x);
    flip6  = ($countones(six_n) != 3) || (!k_i && x == 5'd7);
    six    = (rd_i && flip6) ? ~six_n : six_n;
    if ($countones(six) > 3)      rd6 = 1'b1;
    else if ($countones(six) < 3) rd6 = 1'b0;
    else                          rd6 = rd_i;

    alt7   = (y == 3'd7) &&
             ((!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
              ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    if (k_i) begin
      four_n = four_k(y);
      flip4  = 1'b1;
      four   = rd6 ? four_n : ~four_n;
    end else begin
      four_n = alt7 ? 4'b0111 : four_neg(y);
      flip4  = ($countones(four_n) != 2) || (y == 3'd3);
      four   = (rd6 && flip4) ? ~four_n : four_n;
    end

    sym_o = {six, four};
    if ($countones(four) > 2)      rd_o = 1'b1;
    else if ($countones(four) < 2) rd_o = 1'b0;
    else                           rd_o = rd6;
  end
endmodule

// File: rtl/pixel_framer.sv
module pixel_framer
  import pixel_framer_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*BYTE_W-1:0] rgb_i,
  input  logic                    hsync_i,
  input  logic                    vsync_i,
  input  logic                    de_i,
  input  logic                    hs_pol_i,
  input  logic                    vs_pol_i,
  output logic [LANES*SYM_W-1:0]  word_o
);
  localparam int unsigned WORD_W = LANES * SYM_W;

  logic                  hs_int, vs_int;
  logic [BYTE_W-1:0]     kbyte;
  logic [LANES:0]        rd_chain;
  logic [WORD_W-1:0]     word_d, word_q;
  logic                  rd_q;

  assign hs_int      = hsync_i ^ hs_pol_i;
  assign vs_int      = vsync_i ^ vs_pol_i;
  assign kbyte       = rst ? {KY_IDLE, K_X} : ctrl_byte(vs_int, hs_int);
  assign rd_chain[0] = rst ? 1'b0 : rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned IN_HI  = (LANES - g) * BYTE_W - 1;
    localparam int unsigned OUT_HI = (LANES - g) * SYM_W - 1;
    logic [BYTE_W-1:0] lane_byte;
    logic              lane_k;

    assign lane_k    = rst || !de_i;
    assign lane_byte = lane_k ? kbyte : rgb_i[IN_HI -: BYTE_W];

    sym_enc8b10b u_enc (
      .byte_i (lane_byte),
      .k_i    (lane_k),
      .rd_i   (rd_chain[g]),
      .sym_o  (word_d[OUT_HI -: SYM_W]),
      .rd_o   (rd_chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    word_q <= word_d;
    rd_q   <= rd_chain[LANES];
  end

  assign word_o = word_q;
endmodule

// File: rtl/pixel_framer_chk.sv
module pixel_framer_chk
  import pixel_framer_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   de_i,
  input logic [LANES*SYM_W-1:0] word_o
);
  int                     run_q;
  int                     run_d;
  logic                   weight_ok, bound_ok, all_k28, no_k28;
  logic [LANES*SYM_W-1:0] reset_word;

  always_comb begin
    run_d     = run_q;
    weight_ok = 1'b1;
    bound_ok  = 1'b1;
    all_k28   = 1'b1;
    no_k28    = 1'b1;
    for (int g = 0; g < LANES; g++) begin
      logic [SYM_W-1:0] s;
      logic             is_k;
      s          = word_o[(LANES-g)*SYM_W-1 -: SYM_W];
      is_k       = (s[9:4] == 6'b001111) || (s[9:4] == 6'b110000);
      all_k28    = all_k28 && is_k;
      no_k28     = no_k28 && !is_k;
      weight_ok  = weight_ok && ($countones(s) >= 4) && ($countones(s) <= 6);
      run_d      = run_d + 2 * $countones(s) - 10;
      bound_ok   = bound_ok && (run_d == 1 || run_d == -1);
      reset_word[(LANES-g)*SYM_W-1 -: SYM_W] =
        (g % 2 == 0) ? 10'b0011111010 : 10'b1100000101;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= -1;
    else     run_q <= run_d;
  end

  AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (rst) weight_ok); // R3
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst) bound_ok); // R3
  AST_ACTIVE_DATA: assert property (@(posedge clk) disable iff (rst) de_i |=> no_k28); // R4
  AST_BLANK_CTRL: assert property (@(posedge clk) disable iff (rst) !de_i |=> all_k28); // R5
  AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> word_o == reset_word); // R7
endmodule

bind pixel_framer pixel_framer_chk #(.LANES(LANES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .de_i   (de_i),
  .word_o (word_o)
);

// File: tb/pixel_framer_test.sv
module pixel_framer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] rgb = '0;
  logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0, hs_pol = 1'b0, vs_pol = 1'b0;
  logic [29:0] word;

  int   checks = 0, errors = 0;
  logic brd = 1'b0;   // model running disparity, 1 = positive
  int   run = -1;     // observed running disparity
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pixel_framer uut (
    .clk(clk), .rst(rst), .rgb_i(rgb), .hsync_i(hsync), .vsync_i(vsync),
    .de_i(de), .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .word_o(word)
  );

  // {negative column, positive column}
  function automatic logic [11:0] t6(input logic [4:0] x);
    case (x)
      5'd0:  return {6'b100111, 6'b011000};  5'd1:  return {6'b011101, 6'b100010};
      5'd2:  return {6'b101101, 6'b010010};  5'd3:  return {6'b110001, 6'b110001};
      5'd4:  return {6'b110101, 6'b001010};  5'd5:  return {6'b101001, 6'b101001};
      5'd6:  return {6'b011001, 6'b011001};  5'd7:  return {6'b111000, 6'b000111};
      5'd8:  return {6'b111001, 6'b000110};  5'd9:  return {6'b100101, 6'b100101};
      5'd10: return {6'b010101, 6'b010101};  5'd11: return {6'b110100, 6'b110100};
      5'd12: return {6'b001101, 6'b001101};  5'd13: return {6'b101100, 6'b101100};
      5'd14: return {6'b011100, 6'b011100};  5'd15: return {6'b010111, 6'b101000};
      5'd16: return {6'b011011, 6'b100100};  5'd17: return {6'b100011, 6'b100011};
      5'd18: return {6'b010011, 6'b010011};  5'd19: return {6'b110010, 6'b110010};
      5'd20: return {6'b001011, 6'b001011};  5'd21: return {6'b101010, 6'b101010};
      5'd22: return {6'b011010, 6'b011010};  5'd23: return {6'b111010, 6'b000101};
      5'd24: return {6'b110011, 6'b001100};  5'd25: return {6'b100110, 6'b100110};
      5'd26: return {6'b010110, 6'b010110};  5'd27: return {6'b110110, 6'b001001};
      5'd28: return {6'b001110, 6'b001110};  5'd29: return {6'b101110, 6'b010001};
      5'd30: return {6'b011110, 6'b100001};  default: return {6'b101011, 6'b010100};
    endcase
  endfunction

  function automatic logic [7:0] t4(input logic [2:0] y, input logic alt);
    if (alt) return {4'b0111, 4'b1000};
    case (y)
      3'd0: return {4'b1011, 4'b0100};  3'd1: return {4'b1001, 4'b1001};
      3'd2: return {4'b0101, 4'b0101};  3'd3: return {4'b1100, 4'b0011};
      3'd4: return {4'b1101, 4'b0010};  3'd5: return {4'b1010, 4'b1010};
      3'd6: return {4'b0110, 4'b0110};  default: return {4'b1110, 4'b0001};
    endcase
  endfunction

  // K28.y full codes {start negative, start positive}
  function automatic logic [19:0] tk(input logic [2:0] y);
    case (y)
      3'd1:    return {10'b0011111001, 10'b1100000110};
      3'd2:    return {10'b0011110101, 10'b1100001010};
      3'd3:    return {10'b0011110011, 10'b1100001100};
      default: return {10'b0011111010, 10'b1100000101};
    endcase
  endfunction

  function automatic void ref_sym(input logic [7:0] b, input logic k, input logic rin,
                                  output logic [9:0] s, output logic rout);
    logic [5:0]  six;
    logic [3:0]  four;
    logic [11:0] e6;
    logic [7:0]  e4;
    logic        r6, alt;
    if (k) begin
      s = rin ? tk(b[7:5])[9:0] : tk(b[7:5])[19:10];
    end else begin
      e6  = t6(b[4:0]);
      six = rin ? e6[5:0] : e6[11:6];
      r6  = ($countones(six) == 3) ? rin : ($countones(six) > 3);
      alt = (b[7:5] == 3'd7) &&
            ((!r6 && (b[4:0] == 17 || b[4:0] == 18 || b[4:0] == 20)) ||
             ( r6 && (b[4:0] == 11 || b[4:0] == 13 || b[4:0] == 14)));
      e4   = t4(b[7:5], alt);
      four = r6 ? e4[3:0] : e4[7:4];
      s    = {six, four};
    end
    rout = ($countones(s) == 5) ? rin : ($countones(s) > 5);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // hsi/vsi are the internal (normalised) sync levels; the pin gets them through the polarity
  task automatic step(input logic r, input logic [23:0] c, input logic hsi, input logic vsi,
                      input logic dei, input logic hpi, input logic vpi, input string tag);
    logic [29:0] expw;
    logic [9:0]  s;
    logic        rdm;
    logic [7:0]  b;
    logic [2:0]  ky;
    @(negedge clk);
    rst = r; rgb = c; de = dei; hs_pol = hpi; vs_pol = vpi;
    hsync = hsi ^ hpi; vsync = vsi ^ vpi;
    @(posedge clk);
    #1;
    case ({vsi, hsi})
      2'b01: ky = 3'd1;  2'b10: ky = 3'd2;  2'b11: ky = 3'd3;  default: ky = 3'd5;
    endcase
    rdm = r ? 1'b0 : brd;
    for (int g = 0; g < 3; g++) begin
      b = r ? 8'hBC : (dei ? c[23-8*g -: 8] : {ky, 5'd28});
      ref_sym(b, r | !dei, rdm, s, rdm);
      expw[29-10*g -: 10] = s;
    end
    brd = rdm;
    check(word === expw, tag, word, expw);
    if (r) run = -1;
    for (int g = 0; g < 3; g++) begin
      int ones;
      ones = $countones(word[29-10*g -: 10]);
      run  = run + 2 * ones - 10;
      check(ones >= 4 && ones <= 6 && (run == 1 || run == -1),
            "R3 symbol weight / running disparity", word, expw);
    end
  endtask

  initial begin
    // R7: reset word
    for (int i = 0; i < 3; i++)
      step(1'b1, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 reset word");
    check(word === {10'b0011111010, 10'b1100000101, 10'b0011111010},
          "R7 reset literal", word, {10'b0011111010, 10'b1100000101, 10'b0011111010});
    // R2: lane order and one-cycle latency, literal codes from positive disparity
    step(1'b0, 24'h000003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 lane order");
    check(word === {10'b0110001011, 10'b0110001011, 10'b1100010100}, "R2 literal word",
          word, {10'b0110001011, 10'b0110001011, 10'b1100010100});
    // R4 / R8: every byte in every lane, two phases
    for (int v = 0; v < 256; v++)
      step(1'b0, {v[7:0], v[7:0] ^ 8'hA5, ~v[7:0]}, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 data sweep");
    for (int v = 0; v < 256; v++)
      step(1'b0, {3{v[7:0]}}, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 alternate sweep");
    // R1 / R5 / R6: syncs under every polarity, colour noise in blanking
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < 3; n++)
          step(1'b0, 24'h5A3C00 ^ (24'h13579B * (n + 1)), s[0], s[1], 1'b0, p[0], p[1],
               "R1 R5 R6 blanking sync map");
    // mixed active and blanking
    for (int v = 0; v < 64; v++)
      step(1'b0, {v[7:0] + 8'hE0, v[7:0] * 3, v[7:0] ^ 8'hF1}, v[1], v[2], v[0] | v[3],
           v[4], v[5], "R4 R5 mixed stream");
    // R7: mid-stream reset restores the negative starting disparity
    step(1'b1, 24'h123456, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 mid-stream reset");
    step(1'b0, 24'hF1F1F1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 R8 after reset");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule